// File: doc/BRIEF.md
# Byte-Wide Memory Front End with Clock Register Window

This block sits behind a classic asynchronous static-memory bus: an address, one bidirectional byte lane, and three active-low strobes for chip select, output enable and write enable. It decodes each bus cycle and steers it to one of two regions. Most of the address space is plain byte storage. The highest eight addresses are a register window shared with a timekeeping core. The window holds one control byte and seven time bytes in BCD.

The timekeeping core does its own counting and is outside this block. Once per second it offers a fresh snapshot of the time, and the window takes that snapshot unless software has paused updates. Two bits of the control byte give software a coherent view. The read-hold bit freezes the seven time bytes so that software can read them. The write-hold bit lets software write new time values. When software clears the write-hold bit, the block hands those values back to the core. The low six bits of the control byte carry a signed calibration setting. The block passes this setting to the core unchanged.

Bus strobes are sampled on the block clock. A write lands on the clock edge it spans. Read data is driven combinationally for as long as a read cycle is asserted.

Top module: `clkwin_sram`

## Requirements
- R1: While bus_ce_n is high the block never drives bus_dq (dq_drive low), and a write strobe in that state changes no byte.
- R2: With bus_ce_n low and bus_we_n low, the byte on bus_dq is stored at bus_addr on the clock edge, whatever the level of bus_oe_n, and dq_drive stays low.
- R3: With bus_ce_n and bus_oe_n low and bus_we_n high, the addressed byte is driven on bus_dq; with bus_oe_n high and bus_we_n high, nothing is driven.
- R4: Each address below the window holds its own byte. Writes to the window never alter the storage bytes.
- R5: After reset, the control byte and all seven time bytes read 00h, cal_setting is 0 and load_stb is low.
- R6: The window sits at the top eight addresses. Offset 0 is control, and offsets 1 to 7 are second, minute, hour, day of week, date, month and year. core_time byte k (bits 8k+7:8k) maps to offset k+1. A tick_1hz pulse copies all seven bytes when control bits 7 and 6 are both 0.
- R7: While control bit 6 (read hold) is 1, ticks leave the time bytes unchanged. After it is cleared, the bytes still hold their values until the next tick, which copies again.
- R8: While control bit 7 (write hold) is 1, ticks leave the time bytes unchanged, and bus writes to time bytes take effect.
- R9: A bus write that changes control bit 7 from 1 to 0 raises load_stb for exactly one cycle, starting at the edge of that write. During that cycle, load_time shows the seven time bytes in core_time packing. No other write raises it.
- R10: cal_setting equals control bits 5:0, where bit 5 is the sign and bits 4:0 are the magnitude.
- R11: If a bus write to a time byte and an enabled tick fall on the same edge, the written byte keeps the bus value and the other time bytes take the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; bus strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (11) | Byte address |
| bus_dq | inout | 8 | Bidirectional data lane |
| bus_ce_n | input | 1 | Chip select, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| dq_drive | output | 1 | High while the block drives bus_dq |
| tick_1hz | input | 1 | One-cycle pulse offering a new time snapshot |
| core_time | input | 56 | Snapshot from the timekeeping core, second in bits 7:0 up to year in bits 55:48 |
| cal_setting | output | 6 | Calibration setting: sign in bit 5, magnitude in bits 4:0 |
| load_stb | output | 1 | One-cycle pulse asking the core to take load_time |
| load_time | output | 56 | Time bytes written by software, same packing as core_time |

## Verification
The bench builds the block with ADDR_W set to 6. This gives 56 storage bytes and puts the window at 38h to 3Fh. At that size every storage address, including the last one just below the window, is cheap to reach. The control byte and all seven time bytes sit within a few cycles of each other. Storage integrity can then be checked again after all the window traffic, and the cases where a tick meets a bus write on the same edge are easy to line up.

// File: rtl/clkwin_pkg.sv
package clkwin_pkg;

   localparam int BYTE_W      = 8;
   localparam int WIN_SLOTS   = 8;
   localparam int TIME_SLOTS  = WIN_SLOTS - 1;
   localparam int TIME_W      = TIME_SLOTS * BYTE_W;
   localparam int SLOT_IDX_W  = $clog2(WIN_SLOTS);
   localparam int HOLD_WR_BIT = 7;
   localparam int HOLD_RD_BIT = 6;
   localparam int CAL_W       = 6;

   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_READ  = 2'd1,
      CYC_WRITE = 2'd2
   } cyc_e;

   typedef struct packed {
      logic                  wr;
      logic [SLOT_IDX_W-1:0] slot;
      logic [BYTE_W-1:0]     wdata;
   } win_req_t;

endpackage

// File: rtl/clkwin_decode.sv
module clkwin_decode
   import clkwin_pkg::*;
#(
   parameter int ADDR_W = 11
)(
   input  logic [ADDR_W-1:0]     addr,
   input  logic                  ce_n,
   input  logic                  oe_n,
   input  logic                  we_n,
   output cyc_e                  cyc,
   output logic                  in_win,
   output logic [SLOT_IDX_W-1:0] slot
);

   localparam int TAG_W = ADDR_W - SLOT_IDX_W;

   if (TAG_W < 1) begin : g_bad_width
      $error("clkwin_decode: ADDR_W too small for the window");
   end

   always_comb begin
      if (ce_n)       cyc = CYC_IDLE;
      else if (!we_n) cyc = CYC_WRITE;
      else if (!oe_n) cyc = CYC_READ;
      else            cyc = CYC_IDLE;
   end

   assign in_win = (addr[ADDR_W-1:SLOT_IDX_W] == {TAG_W{1'b1}});
   assign slot   = addr[SLOT_IDX_W-1:0];

endmodule

// File: rtl/clkwin_store.sv
module clkwin_store
   import clkwin_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DEPTH  = (1 << ADDR_W) - WIN_SLOTS
)(
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata
);

   if (DEPTH < 1 || DEPTH > (1 << ADDR_W)) begin : g_bad_depth
      $error("clkwin_store: DEPTH out of range");
   end

   logic [BYTE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];

endmodule

// File: rtl/clkwin_window.sv
module clkwin_window
   import clkwin_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  win_req_t              req,
   input  logic                  tick,
   input  logic [TIME_W-1:0]     snap,
   output logic [BYTE_W-1:0]     rdata,
   output logic [CAL_W-1:0]      cal,
   output logic [TIME_W-1:0]     time_flat,
   output logic                  load_stb
);

   logic [BYTE_W-1:0] ctrl_q;
   logic              upd_en;
   logic              ctrl_wr;
   logic              load_q;

   assign ctrl_wr = req.wr && (req.slot == '0);
   assign upd_en  = tick && !ctrl_q[HOLD_WR_BIT] && !ctrl_q[HOLD_RD_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= req.wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) load_q <= 1'b0;
      else        load_q <= ctrl_wr && ctrl_q[HOLD_WR_BIT] && !req.wdata[HOLD_WR_BIT];
   end

   for (genvar k = 0; k < TIME_SLOTS; k++) begin : g_slot
      logic [BYTE_W-1:0] q;
      logic              hit;
      assign hit = req.wr && (req.slot == SLOT_IDX_W'(k + 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q <= '0;
         else if (hit)    q <= req.wdata;
         else if (upd_en) q <= snap[k*BYTE_W +: BYTE_W];
      end
      assign time_flat[k*BYTE_W +: BYTE_W] = q;
   end

   always_comb begin
      rdata = ctrl_q;
      for (int k = 1; k < WIN_SLOTS; k++) begin
         if (req.slot == SLOT_IDX_W'(k)) rdata = time_flat[(k-1)*BYTE_W +: BYTE_W];
      end
   end

   assign cal      = ctrl_q[CAL_W-1:0];
   assign load_stb = load_q;

   logic time_wr;
   assign time_wr = req.wr && (req.slot != '0);

   AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> !load_stb); // R9
   AST_LOAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |-> $fell(ctrl_q[HOLD_WR_BIT])); // R9
   AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctrl_q[HOLD_WR_BIT] || ctrl_q[HOLD_RD_BIT]) && !time_wr) |=> $stable(time_flat)); // R7
   AST_TICK_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ctrl_q[HOLD_WR_BIT] && !ctrl_q[HOLD_RD_BIT] && !time_wr) |=> (time_flat == $past(snap))); // R6

endmodule

// File: rtl/clkwin_sram.sv
module clkwin_sram
   import clkwin_pkg::*;
#(
   parameter int ADDR_W = 11
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      bus_addr,
   inout  wire  [BYTE_W-1:0]      bus_dq,
   input  logic                   bus_ce_n,
   input  logic                   bus_oe_n,
   input  logic                   bus_we_n,
   output logic                   dq_drive,
   input  logic                   tick_1hz,
   input  logic [TIME_W-1:0]      core_time,
   output logic [CAL_W-1:0]       cal_setting,
   output logic                   load_stb,
   output logic [TIME_W-1:0]      load_time
);

   localparam int STORE_DEPTH = (1 << ADDR_W) - WIN_SLOTS;

   if (ADDR_W < 4 || ADDR_W > 16) begin : g_bad_addr
      $error("clkwin_sram: ADDR_W must lie in 4..16");
   end

   cyc_e                  cyc;
   logic                  in_win;
   logic [SLOT_IDX_W-1:0] slot;
   logic [BYTE_W-1:0]     store_rd;
   logic [BYTE_W-1:0]     win_rd;
   logic [BYTE_W-1:0]     rd_byte;
   logic                  is_wr;
   win_req_t              wreq;

   clkwin_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr   (bus_addr),
      .ce_n   (bus_ce_n),
      .oe_n   (bus_oe_n),
      .we_n   (bus_we_n),
      .cyc    (cyc),
      .in_win (in_win),
      .slot   (slot)
   );

   assign is_wr      = (cyc == CYC_WRITE);
   assign wreq.wr    = is_wr && in_win;
   assign wreq.slot  = slot;
   assign wreq.wdata = bus_dq;

   clkwin_store #(.ADDR_W(ADDR_W), .DEPTH(STORE_DEPTH)) u_store (
      .clk   (clk),
      .we    (is_wr && !in_win),
      .addr  (bus_addr),
      .wdata (bus_dq),
      .rdata (store_rd)
   );

   clkwin_window u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (wreq),
      .tick      (tick_1hz),
      .snap      (core_time),
      .rdata     (win_rd),
      .cal       (cal_setting),
      .time_flat (load_time),
      .load_stb  (load_stb)
   );

   assign rd_byte  = in_win ? win_rd : store_rd;
   assign dq_drive = (cyc == CYC_READ);
   assign bus_dq   = dq_drive ? rd_byte : 'z;

   AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ce_n |-> !dq_drive); // R1
   AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we_n) |-> !dq_drive); // R2
   AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_ce_n && !bus_oe_n && bus_we_n) |-> dq_drive); // R3

endmodule

// File: tb/clkwin_sram_test.sv
`timescale 1ns/1ps
module clkwin_sram_test;

   localparam int AW = 6;
   localparam logic [AW-1:0] WB = 6'h38;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [7:0]    tb_dq = '0;
   logic          tb_drv = 1'b0;
   wire  [7:0]    bus_dq;
   logic          dq_drive;
   logic          tick = 1'b0;
   logic [55:0]   core_time = '0;
   logic [5:0]    cal;
   logic          load_stb;
   logic [55:0]   load_time;
   int            n_chk = 0, n_bad = 0;
   bit            done = 1'b0;

   assign bus_dq = tb_drv ? tb_dq : 'z;

   always #2.5 clk = ~clk;

   clkwin_sram #(.ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_dq(bus_dq),
      .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n), .dq_drive(dq_drive),
      .tick_1hz(tick), .core_time(core_time), .cal_setting(cal),
      .load_stb(load_stb), .load_time(load_time)
   );

   // entry: {oe held low during write, address, data}
   localparam logic [14:0] VEC [8] = '{
      {1'b0, 6'h00, 8'h11}, {1'b1, 6'h01, 8'hA2}, {1'b0, 6'h37, 8'h5C},
      {1'b1, 6'h10, 8'hFF}, {1'b0, 6'h20, 8'h00}, {1'b0, 6'h2A, 8'h3C},
      {1'b1, 6'h36, 8'hC3}, {1'b0, 6'h05, 8'h7E}
   };

   localparam logic [55:0] SNAP_A = 56'h24_12_31_07_23_59_58;
   localparam logic [55:0] SNAP_B = 56'h25_01_01_03_00_00_07;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d, input logic oe_low);
      bus_addr = a; tb_dq = d; tb_drv = 1'b1;
      ce_n = 1'b0; we_n = 1'b0; oe_n = !oe_low;
      @(posedge clk); #1;
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tb_drv = 1'b0;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d, output logic drv);
      bus_addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      #1;
      d = bus_dq; drv = dq_drive;
      ce_n = 1'b1; oe_n = 1'b1;
      @(posedge clk); #1;
   endtask

   task automatic expect_byte(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
      logic [7:0] d;
      logic       drv;
      bus_read(a, d, drv);
      check(req, {63'd0, drv}, 64'd1);
      check(req, {56'd0, d}, {56'd0, exp});
   endtask

   task automatic pulse_tick(input logic [55:0] t);
      core_time = t; tick = 1'b1;
      @(posedge clk); #1;
      tick = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R5: reset state
      check("R5 drive", {63'd0, dq_drive}, 64'd0);
      check("R5 cal", {58'd0, cal}, 64'd0);
      check("R5 load", {63'd0, load_stb}, 64'd0);
      expect_byte("R5 ctrl", WB, 8'h00);
      for (int k = 1; k < 8; k++) expect_byte("R5 time", WB + 6'(k), 8'h00);

      // R2 R4: table of storage writes, then read back
      for (int i = 0; i < 8; i++) bus_write(VEC[i][13:8], VEC[i][7:0], VEC[i][14]);
      for (int i = 0; i < 8; i++) expect_byte("R4 storage", VEC[i][13:8], VEC[i][7:0]);

      // R2: no drive during a write even with oe low
      bus_addr = 6'h01; tb_dq = 8'h99; tb_drv = 1'b1; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
      #1 check("R2 no drive", {63'd0, dq_drive}, 64'd0);
      @(posedge clk); #1;
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tb_drv = 1'b0;
      expect_byte("R2 oe-low write", 6'h01, 8'h99);

      // R1: deselected, no drive, write strobe ignored
      bus_addr = 6'h00; ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
      #1 check("R1 no drive", {63'd0, dq_drive}, 64'd0);
      tb_dq = 8'hEE; tb_drv = 1'b1; we_n = 1'b0;
      @(posedge clk); #1;
      we_n = 1'b1; oe_n = 1'b1; tb_drv = 1'b0;
      expect_byte("R1 write ignored", 6'h00, 8'h11);

      // R3: oe high, we high, selected -> no drive
      bus_addr = 6'h00; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
      #1 check("R3 oe high", {63'd0, dq_drive}, 64'd0);
      ce_n = 1'b1;
      @(posedge clk); #1;

      // R6: snapshot copy and byte layout
      pulse_tick(SNAP_A);
      for (int k = 0; k < 7; k++) expect_byte("R6 layout", WB + 6'(k + 1), SNAP_A[k*8 +: 8]);

      // R7: read hold
      bus_write(WB, 8'h40, 1'b0);
      pulse_tick(SNAP_B);
      expect_byte("R7 frozen sec", WB + 6'd1, 8'h58);
      expect_byte("R7 frozen year", WB + 6'd7, 8'h24);
      bus_write(WB, 8'h00, 1'b0);
      expect_byte("R7 no refresh on clear", WB + 6'd1, 8'h58);
      pulse_tick(SNAP_B);
      expect_byte("R7 resumed sec", WB + 6'd1, 8'h07);
      expect_byte("R7 resumed year", WB + 6'd7, 8'h25);

      // R8: write hold
      bus_write(WB, 8'h80, 1'b0);
      bus_write(WB + 6'd1, 8'h15, 1'b0);
      bus_write(WB + 6'd2, 8'h30, 1'b0);
      pulse_tick(SNAP_A);
      expect_byte("R8 sec kept", WB + 6'd1, 8'h15);
      expect_byte("R8 min kept", WB + 6'd2, 8'h30);
      expect_byte("R8 hour not ticked", WB + 6'd3, 8'h00);
      check("R9 no pulse while held", {63'd0, load_stb}, 64'd0);

      // R9: clearing write hold hands bytes to the core
      bus_write(WB, 8'h00, 1'b0);
      check("R9 pulse", {63'd0, load_stb}, 64'd1);
      check("R9 load_time", {8'd0, load_time}, {8'd0, 56'h25_01_01_03_00_30_15});
      @(posedge clk); #1;
      check("R9 one cycle", {63'd0, load_stb}, 64'd0);

      // R10: calibration pass-through, no load pulse when bit 7 already clear
      bus_write(WB, 8'h25, 1'b0);
      check("R10 cal neg", {58'd0, cal}, 64'h25);
      check("R9 no pulse", {63'd0, load_stb}, 64'd0);
      expect_byte("R10 ctrl readback", WB, 8'h25);
      bus_write(WB, 8'h1F, 1'b0);
      check("R10 cal pos", {58'd0, cal}, 64'h1F);
      bus_write(WB, 8'h00, 1'b0);

      // R11: bus write and tick on the same edge
      core_time = SNAP_A; tick = 1'b1;
      bus_write(WB + 6'd1, 8'h42, 1'b0);
      tick = 1'b0;
      expect_byte("R11 bus wins", WB + 6'd1, 8'h42);
      expect_byte("R11 others ticked", WB + 6'd2, 8'h59);
      expect_byte("R11 year ticked", WB + 6'd7, 8'h24);

      // R4: storage untouched by window traffic
      expect_byte("R4 last storage", 6'h37, 8'h5C);
      expect_byte("R4 first storage", 6'h00, 8'h11);
      expect_byte("R4 mid storage", 6'h2A, 8'h3C);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule